// File: doc/BRIEF.md
# Four-Channel PWM Register Front End

This block sits between a simple 32-bit word bus and a bank of PWM waveform generators. It decodes a small global register set (a write-one-to-set start register, a write-one-to-clear stop register, a running-status register, an interrupt mask and a sticky interrupt register) and a per-channel window holding each generator's mode word, active duty, buffered duty, period and buffered period. The stored values are driven out on flattened per-channel ports so that the generators can use them directly.

The generators stay outside the block. Each one reports two things: a one-cycle pulse when it has finished a period and taken its buffered values, and a level showing that it has come to a halt. A channel's status bit goes high when software starts the channel. It drops only after a stop has been requested and the generator reports that it has halted. Period-end pulses collect into a sticky register, and reading that register clears it. The interrupt line is raised while any collected event is unmasked.

Read data is registered: it appears on `bus_rdata` one clock after the read strobe and holds until the next read.

Top module: `pwm_csr_top`

## Requirements
- R1: Writing to byte address 0x04 sets the start request of every channel whose bit in `bus_wdata[3:0]` is 1, and sets that channel's status bit in the same clock. Zero bits leave the request unchanged. The request appears on `ch_en_o`. After reset all requests are 0.
- R2: Writing to byte address 0x08 clears the start request of every channel whose bit in `bus_wdata[3:0]` is 1. Zero bits leave the request unchanged.
- R3: Reading byte address 0x0C returns the running status in bits [3:0]. A status bit clears in the clock after a cycle in which its request is 0 and `ch_idle_i` for that channel is 1. While the request is 1, or while the channel is not idle, the status bit stays set.
- R4: A 1 on `ch_period_evt_i[n]` sets sticky bit n of the interrupt register at byte address 0x1C. The bit stays set until it is cleared by a read.
- R5: A read of byte address 0x1C returns the bits held before the read and clears them all. An event that arrives in the same cycle as the read stays set afterwards.
- R6: `irq_o` is 1 exactly when some interrupt bit is set whose mask bit is also 1. The mask is read and written at byte address 0x10 in bits [3:0] and resets to 0xF.
- R7: Channel n has a window at 0x200 + n*0x20. Within the window, offset 0x00 holds the mode word (11 bits), 0x04 the duty, 0x08 the duty update, 0x0C the period and 0x10 the period update (16 bits each). Reads return the stored bits with zeros above them, and the stored values drive the matching `ch_*_o` slice.
- R8: Reads return 0 from every other address, including the write-only addresses 0x04 and 0x08, the unused window offsets 0x14 to 0x1C, addresses past the last channel's window and unaligned addresses. Writes to those addresses, and writes to 0x0C and 0x1C, change nothing.
- R9: `bus_rdata` takes the value read in the clock after `bus_rd` is sampled and keeps it when no read takes place. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Interrupt, OR of masked sticky events |
| ch_period_evt_i | input | NUM_CH | Per-channel period-end pulse |
| ch_idle_i | input | NUM_CH | Per-channel halted level |
| ch_en_o | output | NUM_CH | Per-channel start request |
| ch_mode_o | output | NUM_CH*MODE_W | Mode words, channel 0 in the low slice |
| ch_duty_o | output | NUM_CH*CNT_W | Active duty values |
| ch_duty_upd_o | output | NUM_CH*CNT_W | Buffered duty values |
| ch_prd_o | output | NUM_CH*CNT_W | Period values |
| ch_prd_upd_o | output | NUM_CH*CNT_W | Buffered period values |

## Verification
The bench builds the block with its default parameters: four channels, a 10-bit address, 16-bit counts and an 11-bit mode word. With these values every channel window falls inside the address space, and so does the unmapped gap directly above the last window. That lets the bench exercise stray addresses as well as the upper-bit truncation of the duty, period and mode fields. Directed sequences cover the lag of the status register behind a stop request, the collision of a period event with a clearing read, and masking. A random phase then mixes bus traffic with event and idle inputs, and a behavioural model is compared against the block on every clock.

// File: rtl/pwm_csr_pkg.sv
package pwm_csr_pkg;

  // Global register byte offsets
  localparam logic [11:0] OFS_START  = 12'h004;
  localparam logic [11:0] OFS_STOP   = 12'h008;
  localparam logic [11:0] OFS_STATUS = 12'h00C;
  localparam logic [11:0] OFS_MASK   = 12'h010;
  localparam logic [11:0] OFS_EVENTS = 12'h01C;

  // Channel windows
  localparam int WIN_BASE    = 32'h200;
  localparam int WIN_SPAN_LG = 5;

  typedef enum logic [2:0] {
    W_MODE     = 3'd0,
    W_DUTY     = 3'd1,
    W_DUTY_UPD = 3'd2,
    W_PRD      = 3'd3,
    W_PRD_UPD  = 3'd4
  } ch_word_e;

  // Next value of a set of sticky bits under a clearing read
  function automatic logic [31:0] sticky_next(input logic [31:0] held,
                                              input logic [31:0] fresh,
                                              input logic        clear);
    return (clear ? 32'h0 : held) | fresh;
  endfunction

  // Status bits that drop: running, no request, generator halted
  function automatic logic [31:0] halted_bits(input logic [31:0] running,
                                              input logic [31:0] request,
                                              input logic [31:0] idle);
    return running & ~request & idle;
  endfunction

endpackage

// File: rtl/pwm_glb_ctrl.sv
module pwm_glb_ctrl
  import pwm_csr_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_we,
  input  logic              stop_we,
  input  logic              mask_we,
  input  logic [NUM_CH-1:0] wbits,
  input  logic [NUM_CH-1:0] idle_i,
  output logic [NUM_CH-1:0] req_q,
  output logic [NUM_CH-1:0] run_q,
  output logic [NUM_CH-1:0] mask_q,
  output logic [NUM_CH-1:0] stop_done
);

  always_comb begin
    stop_done = NUM_CH'(halted_bits(32'(run_q), 32'(req_q), 32'(idle_i)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      run_q  <= '0;
      mask_q <= '1;
    end else begin
      if (start_we) begin
        req_q <= req_q | wbits;
      end else if (stop_we) begin
        req_q <= req_q & ~wbits;
      end
      run_q <= (run_q & ~stop_done) | (start_we ? wbits : '0);
      if (mask_we) begin
        mask_q <= wbits;
      end
    end
  end

endmodule

// File: rtl/pwm_irq_collect.sv
module pwm_irq_collect
  import pwm_csr_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              rd_clr,
  input  logic [NUM_CH-1:0] mask_q,
  output logic [NUM_CH-1:0] evt_q,
  output logic              irq_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= '0;
    end else begin
      evt_q <= NUM_CH'(sticky_next(32'(evt_q), 32'(evt_i), rd_clr));
    end
  end

  assign irq_o = |(evt_q & mask_q);

endmodule

// File: rtl/pwm_ch_window.sv
module pwm_ch_window
  import pwm_csr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int MODE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2:0]        word,
  input  logic [DATA_W-1:0] wdata,
  output logic [MODE_W-1:0] mode_q,
  output logic [CNT_W-1:0]  duty_q,
  output logic [CNT_W-1:0]  duty_upd_q,
  output logic [CNT_W-1:0]  prd_q,
  output logic [CNT_W-1:0]  prd_upd_q,
  output logic [DATA_W-1:0] rd_o
);

  ch_word_e sel;
  assign sel = ch_word_e'(word);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= '0;
      duty_q     <= '0;
      duty_upd_q <= '0;
      prd_q      <= '0;
      prd_upd_q  <= '0;
    end else if (we) begin
      case (sel)
        W_MODE:     mode_q     <= wdata[MODE_W-1:0];
        W_DUTY:     duty_q     <= wdata[CNT_W-1:0];
        W_DUTY_UPD: duty_upd_q <= wdata[CNT_W-1:0];
        W_PRD:      prd_q      <= wdata[CNT_W-1:0];
        W_PRD_UPD:  prd_upd_q  <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      W_MODE:     rd_o = DATA_W'(mode_q);
      W_DUTY:     rd_o = DATA_W'(duty_q);
      W_DUTY_UPD: rd_o = DATA_W'(duty_upd_q);
      W_PRD:      rd_o = DATA_W'(prd_q);
      W_PRD_UPD:  rd_o = DATA_W'(prd_upd_q);
      default:    rd_o = '0;
    endcase
  end

endmodule

// File: rtl/pwm_csr_top.sv
module pwm_csr_top
  import pwm_csr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int MODE_W = 11
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     irq_o,
  input  logic [NUM_CH-1:0]        ch_period_evt_i,
  input  logic [NUM_CH-1:0]        ch_idle_i,
  output logic [NUM_CH-1:0]        ch_en_o,
  output logic [NUM_CH*MODE_W-1:0] ch_mode_o,
  output logic [NUM_CH*CNT_W-1:0]  ch_duty_o,
  output logic [NUM_CH*CNT_W-1:0]  ch_duty_upd_o,
  output logic [NUM_CH*CNT_W-1:0]  ch_prd_o,
  output logic [NUM_CH*CNT_W-1:0]  ch_prd_upd_o
);

  localparam int CH_IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int WIN_BYTES = NUM_CH << WIN_SPAN_LG;

  // Address decode
  logic [ADDR_W-1:0]   ch_off;
  logic                ch_hit;
  logic [CH_IDX_W-1:0] ch_idx;
  logic [2:0]          ch_word;
  logic hit_start, hit_stop, hit_status, hit_mask, hit_events;

  assign ch_off  = bus_addr - ADDR_W'(WIN_BASE);
  assign ch_hit  = (bus_addr >= ADDR_W'(WIN_BASE)) &&
                   (ch_off < ADDR_W'(WIN_BYTES)) && (ch_off[1:0] == 2'b00);
  assign ch_idx  = ch_off[WIN_SPAN_LG +: CH_IDX_W];
  assign ch_word = ch_off[4:2];

  assign hit_start  = (bus_addr == ADDR_W'(OFS_START));
  assign hit_stop   = (bus_addr == ADDR_W'(OFS_STOP));
  assign hit_status = (bus_addr == ADDR_W'(OFS_STATUS));
  assign hit_mask   = (bus_addr == ADDR_W'(OFS_MASK));
  assign hit_events = (bus_addr == ADDR_W'(OFS_EVENTS));

  // Named internal events and state
  logic              start_we, stop_we, mask_we, events_rd;
  logic [NUM_CH-1:0] st_q, isr_q, mask_q, stop_done;

  assign start_we  = bus_wr & hit_start;
  assign stop_we   = bus_wr & hit_stop;
  assign mask_we   = bus_wr & hit_mask;
  assign events_rd = bus_rd & hit_events;

  pwm_glb_ctrl #(.NUM_CH(NUM_CH)) u_glb (
    .clk      (clk),
    .rst      (rst),
    .start_we (start_we),
    .stop_we  (stop_we),
    .mask_we  (mask_we),
    .wbits    (bus_wdata[NUM_CH-1:0]),
    .idle_i   (ch_idle_i),
    .req_q    (ch_en_o),
    .run_q    (st_q),
    .mask_q   (mask_q),
    .stop_done(stop_done)
  );

  pwm_irq_collect #(.NUM_CH(NUM_CH)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .evt_i (ch_period_evt_i),
    .rd_clr(events_rd),
    .mask_q(mask_q),
    .evt_q (isr_q),
    .irq_o (irq_o)
  );

  // Channel windows
  logic [DATA_W-1:0] ch_rd [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic win_we;
    assign win_we = bus_wr & ch_hit & (ch_idx == CH_IDX_W'(g));

    pwm_ch_window #(.DATA_W(DATA_W), .CNT_W(CNT_W), .MODE_W(MODE_W)) u_win (
      .clk       (clk),
      .rst       (rst),
      .we        (win_we),
      .word      (ch_word),
      .wdata     (bus_wdata),
      .mode_q    (ch_mode_o[g*MODE_W +: MODE_W]),
      .duty_q    (ch_duty_o[g*CNT_W +: CNT_W]),
      .duty_upd_q(ch_duty_upd_o[g*CNT_W +: CNT_W]),
      .prd_q     (ch_prd_o[g*CNT_W +: CNT_W]),
      .prd_upd_q (ch_prd_upd_o[g*CNT_W +: CNT_W]),
      .rd_o      (ch_rd[g])
    );
  end

  // Read mux and registered read data
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (ch_hit)          rd_mux = ch_rd[ch_idx];
    else if (hit_status) rd_mux = DATA_W'(st_q);
    else if (hit_mask)   rd_mux = DATA_W'(mask_q);
    else if (hit_events) rd_mux = DATA_W'(isr_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/pwm_csr_chk.sv
module pwm_csr_chk
  import pwm_csr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [NUM_CH-1:0] ch_period_evt_i,
  input logic [NUM_CH-1:0] ch_idle_i,
  input logic [NUM_CH-1:0] ch_en_o,
  input logic              irq_o,
  input logic [NUM_CH-1:0] st_q,
  input logic [NUM_CH-1:0] isr_q,
  input logic [NUM_CH-1:0] mask_q
);

  assert_start_sets_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_START)) |=>
      ((ch_en_o & $past(bus_wdata[NUM_CH-1:0])) == $past(bus_wdata[NUM_CH-1:0])));

  assert_req_has_status_R1: assert property (@(posedge clk) disable iff (rst)
    ((ch_en_o & ~st_q) == '0));

  assert_stop_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_STOP)) |=>
      ((ch_en_o & $past(bus_wdata[NUM_CH-1:0])) == '0));

  assert_status_lags_R3: assert property (@(posedge clk) disable iff (rst)
    ((st_q & ~ch_idle_i) != '0) |=>
      ((st_q & $past(st_q & ~ch_idle_i)) == $past(st_q & ~ch_idle_i)));

  assert_event_sticks_R4: assert property (@(posedge clk) disable iff (rst)
    (ch_period_evt_i != '0) |=>
      ((isr_q & $past(ch_period_evt_i)) == $past(ch_period_evt_i)));

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFS_EVENTS)) |=>
      ((isr_q & ~$past(ch_period_evt_i)) == '0));

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    ((isr_q & mask_q) == '0) |-> !irq_o);

endmodule

bind pwm_csr_top pwm_csr_chk #(
  .NUM_CH(NUM_CH),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .bus_addr       (bus_addr),
  .bus_wr         (bus_wr),
  .bus_rd         (bus_rd),
  .bus_wdata      (bus_wdata),
  .ch_period_evt_i(ch_period_evt_i),
  .ch_idle_i      (ch_idle_i),
  .ch_en_o        (ch_en_o),
  .irq_o          (irq_o),
  .st_q           (st_q),
  .isr_q          (isr_q),
  .mask_q         (mask_q)
);

// File: tb/sim_pwm_csr_top.sv
`timescale 1ns/100ps
module sim_pwm_csr_top;

  localparam int NCH = 4;
  localparam int AW  = 10;
  localparam int DW  = 32;
  localparam int CW  = 16;
  localparam int MW  = 11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [AW-1:0]     bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [DW-1:0]     bus_wdata = '0;
  logic [DW-1:0]     bus_rdata;
  logic              irq_o;
  logic [NCH-1:0]    evt = '0;
  logic [NCH-1:0]    idle = '0;
  logic [NCH-1:0]    ch_en_o;
  logic [NCH*MW-1:0] ch_mode_o;
  logic [NCH*CW-1:0] ch_duty_o, ch_duty_upd_o, ch_prd_o, ch_prd_upd_o;

  always #2.5 clk = ~clk;

  pwm_csr_top u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .ch_period_evt_i(evt), .ch_idle_i(idle), .ch_en_o(ch_en_o),
    .ch_mode_o(ch_mode_o), .ch_duty_o(ch_duty_o), .ch_duty_upd_o(ch_duty_upd_o),
    .ch_prd_o(ch_prd_o), .ch_prd_upd_o(ch_prd_upd_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_req, m_run, m_mask, m_evt, m_rdata;
  int m_fld [NCH][5];

  function automatic int model_read(int a);
    int off;
    if (a == 'h0C) return m_run;
    if (a == 'h10) return m_mask;
    if (a == 'h1C) return m_evt;
    if (a >= 'h200 && a < 'h200 + NCH * 32 && (a % 4) == 0) begin
      off = (a - 'h200) % 32;
      if (off <= 'h10) return m_fld[(a - 'h200) / 32][off / 4];
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_req = 0; m_run = 0; m_mask = 'hF; m_evt = 0; m_rdata = 0;
      foreach (m_fld[c, k]) m_fld[c][k] = 0;
    end else begin
      int a, w, nrun;
      a = int'(bus_addr);
      w = int'(bus_wdata);
      if (bus_rd) m_rdata = model_read(a);
      nrun = m_run;
      for (int c = 0; c < NCH; c++)
        if (m_run[c] && !m_req[c] && idle[c]) nrun[c] = 1'b0;
      if (bus_wr) begin
        if (a == 'h04) begin m_req |= (w & 'hF); nrun |= (w & 'hF); end
        else if (a == 'h08) m_req &= ~(w & 'hF);
        else if (a == 'h10) m_mask = w & 'hF;
        else if (a >= 'h200 && a < 'h200 + NCH * 32 && (a % 4) == 0) begin
          int off;
          off = (a - 'h200) % 32;
          if (off == 0) m_fld[(a - 'h200) / 32][0] = w & 'h7FF;
          else if (off <= 'h10) m_fld[(a - 'h200) / 32][off / 4] = w & 'hFFFF;
        end
      end
      m_run = nrun;
      if (bus_rd && a == 'h1C) m_evt = 0;
      m_evt |= int'(evt);
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R9/R5/R7/R8 rdata vs model", bus_rdata, m_rdata);
      chk("R6 irq vs model", irq_o, ((m_evt & m_mask) != 0));
      chk("R1/R2 ch_en vs model", ch_en_o, m_req);
      for (int c = 0; c < NCH; c++) begin
        chk("R7 mode port", ch_mode_o[c*MW +: MW], m_fld[c][0]);
        chk("R7 duty port", ch_duty_o[c*CW +: CW], m_fld[c][1]);
        chk("R7 duty update port", ch_duty_upd_o[c*CW +: CW], m_fld[c][2]);
        chk("R7 period port", ch_prd_o[c*CW +: CW], m_fld[c][3]);
        chk("R7 period update port", ch_prd_upd_o[c*CW +: CW], m_fld[c][4]);
      end
    end
  end

  // Bus tasks: inputs change just after a falling edge
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    bus_addr = AW'(a); bus_wdata = DW'(d); bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    bus_addr = AW'(a); bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
    v = int'(bus_rdata);
  endtask

  task automatic pulse(logic [NCH-1:0] e);
    evt = e;
    tick();
    evt = '0;
  endtask

  initial begin
    #(5ns * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  int addr_pool [12] = '{'h04, 'h08, 'h0C, 'h10, 'h1C, 'h00, 'h200, 'h224,
                         'h248, 'h26C, 'h270, 'h290};

  initial begin
    int v;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // Reset state
    chk("R9 reset rdata", bus_rdata, 0);
    chk("R1 reset requests", ch_en_o, 0);
    chk("R6 reset irq", irq_o, 0);
    rd('h10, v); chk("R6 mask reset value", v, 'hF);
    rd('h0C, v); chk("R3 status after reset", v, 0);

    // Start
    wr('h04, 'h5);
    chk("R1 start 0x5", ch_en_o, 'h5);
    rd('h0C, v); chk("R1 status set by start", v, 'h5);
    wr('h04, 'h2);
    chk("R1 zero bits keep requests", ch_en_o, 'h7);

    // Stop and status lag
    wr('h08, 'h1);
    chk("R2 stop ch0", ch_en_o, 'h6);
    rd('h0C, v); chk("R3 status held until halted", v, 'h7);
    idle = 4'b0011;
    tick();
    idle = '0;
    rd('h0C, v); chk("R3 halted ch0 drops, running ch1 stays", v, 'h6);
    wr('h08, 'h0);
    chk("R2 zero stop bits no effect", ch_en_o, 'h6);

    // Sticky events and clear on read
    pulse(4'b0100);
    tick();
    chk("R4 irq from sticky event", irq_o, 1);
    rd('h1C, v); chk("R5 read returns sticky", v, 'h4);
    rd('h1C, v); chk("R5 cleared by read", v, 0);
    pulse(4'b0010);
    evt = 4'b1000;
    rd('h1C, v);
    evt = '0;
    chk("R5 read during new event", v, 'h2);
    rd('h1C, v); chk("R5 colliding event kept", v, 'h8);

    // Mask
    wr('h10, 'h0);
    pulse(4'b0001);
    chk("R6 masked event no irq", irq_o, 0);
    wr('h10, 'h1);
    chk("R6 unmasked irq", irq_o, 1);
    rd('h1C, v);
    chk("R6 irq low after clear", irq_o, 0);
    wr('h10, 'hF);

    // Channel windows
    wr('h240, 'hFFFF_FFFF);
    wr('h244, 'h1234_5678);
    wr('h248, 'h0000_ABCD);
    wr('h24C, 'h0003_0100);
    wr('h250, 'h0000_0200);
    wr('h26C, 'h0000_7777);
    rd('h240, v); chk("R7 mode truncated to 11 bits", v, 'h7FF);
    rd('h244, v); chk("R7 duty truncated to 16 bits", v, 'h5678);
    rd('h248, v); chk("R7 duty update", v, 'hABCD);
    rd('h24C, v); chk("R7 period", v, 'h0100);
    rd('h250, v); chk("R7 period update", v, 'h0200);
    chk("R7 ch3 period port", ch_prd_o[3*CW +: CW], 'h7777);
    chk("R7 ch2 duty port", ch_duty_o[2*CW +: CW], 'h5678);

    // Unmapped and read-only
    wr('h254, 'h1111);
    wr('h290, 'h2222);
    wr('h000, 'h3333);
    wr('h0C, 'h0);
    wr('h1C, 'hF);
    rd('h254, v); chk("R8 unused window offset", v, 0);
    rd('h290, v); chk("R8 past last window", v, 0);
    rd('h04, v);  chk("R8 start reads zero", v, 0);
    rd('h242, v); chk("R8 unaligned reads zero", v, 0);
    rd('h0C, v);  chk("R8 status write ignored", v, 'h6);
    rd('h1C, v);  chk("R8 event write ignored", v, 0);

    // Read data holds
    rd('h240, v);
    wr('h244, 'h9);
    tick(); tick();
    chk("R9 rdata held without read", bus_rdata, 'h7FF);

    // Random traffic, compared against the model each clock
    for (int i = 0; i < 600; i++) begin
      int sel;
      evt  = NCH'($urandom_range(0, 15) & $urandom_range(0, 15));
      idle = NCH'($urandom_range(0, 15));
      sel  = $urandom_range(0, 2);
      bus_addr  = AW'(addr_pool[$urandom_range(0, 11)]);
      bus_wdata = DW'($urandom);
      bus_wr = (sel == 0);
      bus_rd = (sel == 1);
      tick();
      bus_wr = 1'b0; bus_rd = 1'b0; evt = '0;
    end
    tick();

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule